// File: doc/BRIEF.md
# Half-Cycle Gate Pattern PWM Generator

This block drives the six gates of a single-phase buck–boost inverter built around a split input capacitor. Two of the switches are chopped at the PWM rate and set the energy moved in each switching period. The other four form two pairs, and the grid polarity picks which pair conducts for the whole half cycle. The duty command of each chopped switch comes from an outer regulator. In every half cycle, one of the two duty paths is shaped by the rectified, grid-locked sine magnitude, so the current sent to the grid follows a sine. The other path passes its command through unchanged and only balances charge between the two capacitor halves. The two paths swap these roles when the polarity flips.

A free-running carrier counter sets the switching period. Duty commands, the sine magnitude and the polarity are captured only at the carrier wrap, so an input that moves inside a period cannot cut a pulse short or change which pair conducts. When the polarity does change, all four line-frequency gates go low for a programmable dead interval before the new pair turns on. Both duties are limited to a programmable ceiling, so each inductor has time to discharge within the period.

Top module: `phase_gate_pwm`

## Requirements
- R1: The carrier counter runs freely through 2^W states, from 0 to 2^W-1, and then wraps. Each chopped gate is high exactly while the counter is below its latched duty, so a pulse can only begin at counter value 0.
- R2: When polarity is positive (pol_pos=1), the first duty is p1_cmd. The second duty is floor(p2_cmd*sine_mag/2^W).
- R3: When polarity is negative (pol_pos=0), the first duty is floor(p1_cmd*sine_mag/2^W). The second duty is p2_cmd.
- R4: Each duty is limited to at most duty_max before it is latched.
- R5: p1_cmd, p2_cmd, sine_mag, duty_max and pol_pos are sampled only on the clock edge where the counter wraps from 2^W-1 to 0. A change at any other time has no effect on the gates until the next period.
- R6: With positive polarity, sw_pos_a and sw_pos_b are high together and both negative-pair gates are low. With negative polarity, sw_neg_a and sw_neg_b are high together and both positive-pair gates are low. The two pairs are never on at once.
- R7: In the first period after reset, and in any period that starts with a polarity different from the one applied before, all four line gates stay low for the first max(dead_cycles,1) clock cycles of the period. The new pair then turns on for the rest of the period. A period with unchanged polarity keeps its pair on for the whole period.
- R8: Synchronous active-high reset drives all six gates low and clears the counter. The whole first carrier period after reset leaves all six gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_pos | input | 1 | Grid polarity, 1 = positive half cycle |
| p1_cmd | input | W | Duty command of the first chopped path, fraction of 2^W |
| p2_cmd | input | W | Duty command of the second chopped path, fraction of 2^W |
| sine_mag | input | W | Rectified unit sine magnitude, fraction of 2^W |
| duty_max | input | W | Duty ceiling applied to both paths |
| dead_cycles | input | DTW | Line-gate dead interval in clock cycles |
| sw_hf_a | output | 1 | Chopped gate of the first path |
| sw_hf_b | output | 1 | Chopped gate of the second path |
| sw_pos_a | output | 1 | Line gate held on in the positive half cycle |
| sw_pos_b | output | 1 | Second line gate held on in the positive half cycle |
| sw_neg_a | output | 1 | Line gate held on in the negative half cycle |
| sw_neg_b | output | 1 | Second line gate held on in the negative half cycle |

## Verification
The sweep covers commands of zero and full scale, sine magnitudes of 0, 1 and near full scale, and three ceilings. A design that multiplies on the wrong path for one polarity, rounds instead of truncating, or clamps before shaping gives the wrong pulse width in some period. Polarity flips are mixed with dead intervals of zero and nonzero length. A dead count that is off by one, or a new pair that turns on while the old one is still on, shows up in the per-cycle line-gate pattern. Commands and polarity are also toggled in the middle of a period. A design that picks up inputs outside the wrap edge would reshape a pulse or switch a pair early.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_DEAD = 2'd1,
    LS_ON   = 2'd2
  } line_state_t;

  // Fractional product: both operands are fractions of 2^w, result truncated.
  function automatic logic [31:0] frac_mul(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input int unsigned w);
    logic [63:0] prod;
    prod = 64'(a) * 64'(b);
    return 32'(prod >> w);
  endfunction

  // Upper limit.
  function automatic logic [31:0] clamp_max(input logic [31:0] v,
                                            input logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/pgp_carrier.sv
module pgp_carrier #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = '1;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pgp_duty_path.sv
module pgp_duty_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shape,
  input  logic [W-1:0] p_cmd,
  input  logic [W-1:0] amag,
  input  logic [W-1:0] duty_max,
  output logic [W-1:0] duty_q
);
  import pgp_pkg::*;

  logic [31:0]  shaped;
  logic [W-1:0] duty_nxt;

  always_comb begin
    shaped   = shape ? frac_mul(32'(p_cmd), 32'(amag), W) : 32'(p_cmd);
    duty_nxt = W'(clamp_max(shaped, 32'(duty_max)));
  end

  always_ff @(posedge clk) begin
    if (rst)       duty_q <= '0;
    else if (load) duty_q <= duty_nxt;
  end
endmodule

// File: rtl/pgp_line_seq.sv
module pgp_line_seq #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wrap,
  input  logic           pol_in,
  input  logic [DTW-1:0] dead_cycles,
  output logic           pos_on,
  output logic           neg_on,
  output logic           dead_active
);
  import pgp_pkg::*;

  line_state_t    st;
  logic           pol_act;
  logic [DTW-1:0] rem;
  logic           restart;

  assign restart     = wrap && ((st == LS_IDLE) || (pol_in != pol_act));
  assign dead_active = (st == LS_DEAD);
  assign pos_on      = (st == LS_ON) && pol_act;
  assign neg_on      = (st == LS_ON) && !pol_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LS_IDLE;
      pol_act <= 1'b0;
      rem     <= '0;
    end else if (restart) begin
      st      <= LS_DEAD;
      pol_act <= pol_in;
      rem     <= dead_cycles;
    end else if (st == LS_DEAD) begin
      if (rem <= DTW'(1)) st  <= LS_ON;
      else                rem <= rem - DTW'(1);
    end
  end
endmodule

// File: rtl/phase_gate_pwm.sv
module phase_gate_pwm #(
  parameter int W   = 12,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pol_pos,
  input  logic [W-1:0]   p1_cmd,
  input  logic [W-1:0]   p2_cmd,
  input  logic [W-1:0]   sine_mag,
  input  logic [W-1:0]   duty_max,
  input  logic [DTW-1:0] dead_cycles,
  output logic           sw_hf_a,
  output logic           sw_hf_b,
  output logic           sw_pos_a,
  output logic           sw_pos_b,
  output logic           sw_neg_a,
  output logic           sw_neg_b
);
  localparam int NPATH = 2;

  logic [W-1:0] carrier_cnt;
  logic         wrap_evt;
  logic         dead_active;
  logic         pos_on;
  logic         neg_on;
  logic [W-1:0] duty_q [NPATH];
  logic [W-1:0] d1_q;
  logic [W-1:0] d2_q;

  pgp_carrier #(.W(W)) u_carrier (
    .clk  (clk),
    .rst  (rst),
    .cnt  (carrier_cnt),
    .wrap (wrap_evt)
  );

  // Path 0 is shaped in the negative half cycle, path 1 in the positive one.
  for (genvar g = 0; g < NPATH; g++) begin : g_path
    localparam bit SHAPE_ON_POS = (g == 1);
    pgp_duty_path #(.W(W)) u_path (
      .clk      (clk),
      .rst      (rst),
      .load     (wrap_evt),
      .shape    (SHAPE_ON_POS ? pol_pos : !pol_pos),
      .p_cmd    ((g == 0) ? p1_cmd : p2_cmd),
      .amag     (sine_mag),
      .duty_max (duty_max),
      .duty_q   (duty_q[g])
    );
  end

  assign d1_q = duty_q[0];
  assign d2_q = duty_q[1];

  pgp_line_seq #(.DTW(DTW)) u_line (
    .clk         (clk),
    .rst         (rst),
    .wrap        (wrap_evt),
    .pol_in      (pol_pos),
    .dead_cycles (dead_cycles),
    .pos_on      (pos_on),
    .neg_on      (neg_on),
    .dead_active (dead_active)
  );

  assign sw_hf_a  = (carrier_cnt < d1_q);
  assign sw_hf_b  = (carrier_cnt < d2_q);
  assign sw_pos_a = pos_on;
  assign sw_pos_b = pos_on;
  assign sw_neg_a = neg_on;
  assign sw_neg_b = neg_on;
endmodule

// File: rtl/pgp_checker.sv
module pgp_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] duty_max,
  input logic [W-1:0] carrier_cnt,
  input logic         wrap_evt,
  input logic         dead_active,
  input logic [W-1:0] d1_q,
  input logic [W-1:0] d2_q,
  input logic         sw_hf_a,
  input logic         sw_hf_b,
  input logic         sw_pos_a,
  input logic         sw_pos_b,
  input logic         sw_neg_a,
  input logic         sw_neg_b
);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!sw_hf_a && !sw_hf_b && !sw_pos_a && !sw_pos_b && !sw_neg_a && !sw_neg_b
             && carrier_cnt == '0));

  a_r6_pairs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((sw_pos_a || sw_pos_b) && (sw_neg_a || sw_neg_b)));

  a_r1_pulse_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(sw_hf_a) || $rose(sw_hf_b)) |-> (carrier_cnt == '0));

  a_r4_duty_clamped: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (d1_q <= $past(duty_max) && d2_q <= $past(duty_max)));

  a_r5_duty_held: assert property (@(posedge clk) disable iff (rst)
    !$past(wrap_evt) |-> ($stable(d1_q) && $stable(d2_q)));

  a_r5_line_off_at_wrap: assert property (@(posedge clk) disable iff (rst)
    ($fell(sw_pos_a) || $fell(sw_neg_a)) |-> $past(wrap_evt));

  a_r7_dead_before_on: assert property (@(posedge clk) disable iff (rst)
    ($rose(sw_pos_a) || $rose(sw_neg_a)) |->
      $past(dead_active && !sw_pos_a && !sw_neg_a));

endmodule

bind phase_gate_pwm pgp_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .duty_max    (duty_max),
  .carrier_cnt (carrier_cnt),
  .wrap_evt    (wrap_evt),
  .dead_active (dead_active),
  .d1_q        (d1_q),
  .d2_q        (d2_q),
  .sw_hf_a     (sw_hf_a),
  .sw_hf_b     (sw_hf_b),
  .sw_pos_a    (sw_pos_a),
  .sw_pos_b    (sw_pos_b),
  .sw_neg_a    (sw_neg_a),
  .sw_neg_b    (sw_neg_b)
);

// File: tb/test_phase_gate_pwm.sv
module test_phase_gate_pwm;
  localparam int W   = 6;
  localparam int DTW = 4;
  localparam int PER = 1 << W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           pol_pos = 1'b1;
  logic [W-1:0]   p1_cmd = '0, p2_cmd = '0, sine_mag = '0, duty_max = '1;
  logic [DTW-1:0] dead_cycles = '0;
  logic sw_hf_a, sw_hf_b, sw_pos_a, sw_pos_b, sw_neg_a, sw_neg_b;

  phase_gate_pwm #(.W(W), .DTW(DTW)) i_phase_gate_pwm (
    .clk(clk), .rst(rst), .pol_pos(pol_pos), .p1_cmd(p1_cmd), .p2_cmd(p2_cmd),
    .sine_mag(sine_mag), .duty_max(duty_max), .dead_cycles(dead_cycles),
    .sw_hf_a(sw_hf_a), .sw_hf_b(sw_hf_b), .sw_pos_a(sw_pos_a), .sw_pos_b(sw_pos_b),
    .sw_neg_a(sw_neg_a), .sw_neg_b(sw_neg_b)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected duty from the requirement text: shaped = product / full scale.
  function automatic int exp_duty(input int p, input int a, input bit shaped, input int lim);
    int v;
    v = shaped ? (p * a) / PER : p;
    return (v > lim) ? lim : v;
  endfunction

  function automatic int all_gates();
    return int'(sw_hf_a) + int'(sw_hf_b) + int'(sw_pos_a) + int'(sw_pos_b)
         + int'(sw_neg_a) + int'(sw_neg_b);
  endfunction

  int pv_t[5] = '{0, 1, 21, 48, 63};
  int av_t[4] = '{0, 1, 33, 63};
  int dm_t[3] = '{63, 40, 9};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit prev_pol;
    bit first;
    int bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(all_gates() == 0, "R8 gates low in reset", all_gates(), 0);
    rst = 1'b0;

    // R8: whole first period idle
    bad = 0;
    for (int k = 0; k < PER; k++) begin
      if (all_gates() != 0) bad++;
      if (k < PER - 1) @(negedge clk);
    end
    check(bad == 0, "R8 first period idle", bad, 0);

    prev_pol = 1'b0;
    first    = 1'b1;
    for (int i = 0; i < 240; i++) begin
      int  pv, av, dm, d, e1, e2, dl;
      bit  pol, glitch, changed;
      int  bad1, bad2, badp, badn, n1, n2, np, nn;
      pv     = pv_t[i % 5];
      av     = av_t[(i / 5) % 4];
      dm     = dm_t[(i / 20) % 3];
      pol    = ((i / 3) % 2) == 0;
      d      = (i / 6) % 7;
      glitch = (i % 4) == 1;

      // drive at the negedge before the wrap edge
      p1_cmd      = W'(pv);
      p2_cmd      = W'(PER - 1 - pv);
      sine_mag    = W'(av);
      duty_max    = W'(dm);
      pol_pos     = pol;
      dead_cycles = DTW'(d);

      e1      = exp_duty(pv, av, !pol, dm);
      e2      = exp_duty(PER - 1 - pv, av, pol, dm);
      changed = first || (pol != prev_pol);
      dl      = changed ? ((d == 0) ? 1 : d) : 0;

      bad1 = 0; bad2 = 0; badp = 0; badn = 0; n1 = 0; n2 = 0; np = 0; nn = 0;
      for (int k = 0; k < PER; k++) begin
        bit ep, en;
        @(negedge clk);
        ep = pol && (k >= dl);
        en = !pol && (k >= dl);
        if (sw_hf_a !== (k < e1)) bad1++;
        if (sw_hf_b !== (k < e2)) bad2++;
        if (sw_pos_a !== ep || sw_pos_b !== ep) badp++;
        if (sw_neg_a !== en || sw_neg_b !== en) badn++;
        n1 += int'(sw_hf_a);
        n2 += int'(sw_hf_b);
        np += int'(sw_pos_a);
        nn += int'(sw_neg_a);
        if (glitch && k == 20) begin
          // R5: mid-period changes must not reach the gates
          p1_cmd   = ~p1_cmd;
          p2_cmd   = ~p2_cmd;
          sine_mag = ~sine_mag;
          duty_max = '1;
          pol_pos  = ~pol_pos;
        end
      end

      check(bad1 == 0 && n1 == e1,
            $sformatf("R1 %s%s%s path A vec %0d", pol ? "R2" : "R3",
                      (e1 == dm) ? " R4" : "", glitch ? " R5" : "", i), n1, e1);
      check(bad2 == 0 && n2 == e2,
            $sformatf("R1 %s%s%s path B vec %0d", pol ? "R2" : "R3",
                      (e2 == dm) ? " R4" : "", glitch ? " R5" : "", i), n2, e2);
      check(badp == 0,
            $sformatf("R6 R7%s positive pair vec %0d", glitch ? " R5" : "", i),
            np, pol ? PER - dl : 0);
      check(badn == 0,
            $sformatf("R6 R7%s negative pair vec %0d", glitch ? " R5" : "", i),
            nn, pol ? 0 : PER - dl);

      prev_pol = pol;
      first    = 1'b0;
    end

    // R8: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(all_gates() == 0, "R8 gates low after mid-run reset", all_gates(), 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule